// File: doc/BRIEF.md
# Three-Address Memory-to-Memory Core

A small multicycle processor that keeps no data registers. Every operand and every result is a 32-bit word in byte-addressed memory, reached through one byte-wide port on an internal RAM. Each instruction names its destination and both sources as full 24-bit byte addresses. The core steps through the instruction bytes, reads the two source words, computes, writes the destination word back, and then moves its program counter past the instruction.

A test port loads a program and its data into the RAM while the core is idle, and reads memory back after the core has stopped. A one-cycle `run` pulse starts execution at address 0. The core then runs until a halt instruction or an unknown opcode stops it. Only the low `MEM_AW` bits of any address select a RAM byte, so higher addresses alias onto the RAM.

Top module: `mm3_core`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `busy`=0, `done`=0, `illegal`=0 and `pc`=0. RAM contents survive reset.
- R2: When the core is not busy, a test-port write stores `tp_wdata` at byte `tp_addr`. `tp_rdata` returns the byte at `tp_addr` one clock after the address is presented.
- R3: An instruction is 10 bytes at `pc`. Byte 0 is the opcode. It is followed by three 24-bit fields, each stored most significant byte first: destination, then first source, then second source. Only the low `MEM_AW` bits of each field address the RAM.
- R4: Opcode 0x01 writes (first source + second source) mod 2^32 to the destination. Words are little-endian, so the lowest byte is at the lowest address.
- R5: Opcode 0x02 writes (first source − second source) mod 2^32.
- R6: Opcode 0x03 writes the low 32 bits of first source × second source.
- R7: Instructions execute strictly one after another, so a later instruction sees every byte written by an earlier one, even when the destination equals a source. `pc` grows by exactly 10 after each arithmetic instruction.
- R8: Opcode 0xFF raises `done` for exactly one cycle, clears `busy`, and leaves `pc` at the address of the halt instruction.
- R9: Any other opcode sets `illegal`, which stays set until reset. The core then stops with `busy`=0, writes nothing, never raises `done`, and leaves `pc` on the offending instruction.
- R10: Test-port writes made while `busy` is 1 do not change memory.
- R11: `run` starts the core only from the idle state that follows reset. After a halt or an illegal stop, `run` has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start pulse, taken only while idle after reset |
| tp_we | input | 1 | Test-port byte write enable |
| tp_addr | input | MEM_AW | Test-port byte address |
| tp_wdata | input | 8 | Test-port write byte |
| tp_rdata | output | 8 | RAM byte read, one cycle latency |
| busy | output | 1 | Core owns the RAM and is executing |
| done | output | 1 | One-cycle pulse on halt |
| illegal | output | 1 | Sticky unknown-opcode flag |
| pc | output | ADDR_W | Program counter |

## Verification
The checker watches every cycle for these properties:
- the reset values of the outputs;
- the one-cycle width of `done`, and that `done` only appears while the core is not busy;
- that `pc` only moves in steps of 10 while running and is frozen when not running;
- that `illegal` stays set and excludes both `busy` and `done`.

Three things can only be shown by the directed scenarios that compare memory against values the bench works out:
- the arithmetic results;
- the byte order of instruction fields and data words;
- that later instructions see earlier results, that test-port writes during a run are dropped, and that a stopped core ignores `run`.

// File: rtl/mm3_pkg.sv
package mm3_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DEC, ST_RDA, ST_RDB, ST_EXE, ST_WR, ST_STOP
  } mm3_state_t;

  localparam logic [7:0] OPC_ADD  = 8'h01;
  localparam logic [7:0] OPC_SUB  = 8'h02;
  localparam logic [7:0] OPC_MUL  = 8'h03;
  localparam logic [7:0] OPC_HALT = 8'hFF;
endpackage

// File: rtl/mm3_ram.sv
module mm3_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/mm3_alu.sv
module mm3_alu
  import mm3_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [7:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OPC_SUB: y = a - b;
      OPC_MUL: y = a * b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/mm3_seq.sv
module mm3_seq
  import mm3_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [7:0]        rdata,
  input  logic [DATA_W-1:0] alu_y,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic [7:0]        opcode,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [ADDR_W-1:0] pc
);
  localparam int IB   = 1 + 3 * (ADDR_W / 8);
  localparam int WB   = DATA_W / 8;
  localparam int IR_W = 8 * IB;
  localparam int CW   = $clog2(IB + 1);
  localparam logic [CW-1:0] CNT_IB = CW'(IB);
  localparam logic [CW-1:0] CNT_WB = CW'(WB);

  mm3_state_t        st;
  logic [CW-1:0]     cnt;
  logic [IR_W-1:0]   ir;
  logic [DATA_W-1:0] res;
  logic [DATA_W-1:0] res_sh;
  logic [ADDR_W-1:0] f_dst, f_a, f_b;

  assign opcode = ir[IR_W-1 -: 8];
  assign f_dst  = ir[3*ADDR_W-1 -: ADDR_W];
  assign f_a    = ir[2*ADDR_W-1 -: ADDR_W];
  assign f_b    = ir[ADDR_W-1:0];
  assign busy   = (st != ST_IDLE) && (st != ST_STOP);

  always_comb begin
    unique case (st)
      ST_RDA:  mem_addr = MEM_AW'(f_a)   + MEM_AW'(cnt);
      ST_RDB:  mem_addr = MEM_AW'(f_b)   + MEM_AW'(cnt);
      ST_WR:   mem_addr = MEM_AW'(f_dst) + MEM_AW'(cnt);
      default: mem_addr = MEM_AW'(pc)    + MEM_AW'(cnt);
    endcase
  end

  assign res_sh    = res >> {cnt, 3'b000};
  assign mem_wdata = res_sh[7:0];
  assign mem_we    = (st == ST_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      pc      <= '0;
      ir      <= '0;
      opa     <= '0;
      opb     <= '0;
      res     <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (run) begin
          st  <= ST_FETCH;
          cnt <= '0;
        end
        ST_FETCH: begin
          if (cnt != '0) ir <= {ir[IR_W-9:0], rdata};
          if (cnt == CNT_IB) begin
            st  <= ST_DEC;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_DEC: begin
          unique case (opcode)
            OPC_ADD, OPC_SUB, OPC_MUL: st <= ST_RDA;
            OPC_HALT: begin
              done <= 1'b1;
              st   <= ST_STOP;
            end
            default: begin
              illegal <= 1'b1;
              st      <= ST_STOP;
            end
          endcase
        end
        ST_RDA: begin
          if (cnt != '0) opa <= {rdata, opa[DATA_W-1:8]};
          if (cnt == CNT_WB) begin
            st  <= ST_RDB;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_RDB: begin
          if (cnt != '0) opb <= {rdata, opb[DATA_W-1:8]};
          if (cnt == CNT_WB) begin
            st  <= ST_EXE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_EXE: begin
          res <= alu_y;
          st  <= ST_WR;
          cnt <= '0;
        end
        ST_WR: begin
          if (cnt == CNT_WB - 1'b1) begin
            st  <= ST_FETCH;
            cnt <= '0;
            pc  <= pc + ADDR_W'(IB);
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_STOP;
      endcase
    end
  end
endmodule

// File: rtl/mm3_core.sv
module mm3_core #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tp_we,
  input  logic [MEM_AW-1:0] tp_addr,
  input  logic [7:0]        tp_wdata,
  output logic [7:0]        tp_rdata,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [ADDR_W-1:0] pc
);
  logic [MEM_AW-1:0] core_addr, ram_addr;
  logic              core_we, ram_we;
  logic [7:0]        core_wdata, ram_wdata, ram_q;
  logic [7:0]        opcode;
  logic [DATA_W-1:0] opa, opb, alu_y;

  mm3_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_seq (
    .clk(clk), .rst(rst), .run(run), .rdata(ram_q), .alu_y(alu_y),
    .mem_addr(core_addr), .mem_we(core_we), .mem_wdata(core_wdata),
    .opcode(opcode), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .illegal(illegal), .pc(pc)
  );

  mm3_alu #(.W(DATA_W)) u_alu (.op(opcode), .a(opa), .b(opb), .y(alu_y));

  assign ram_addr  = busy ? core_addr  : tp_addr;
  assign ram_we    = busy ? core_we    : tp_we;
  assign ram_wdata = busy ? core_wdata : tp_wdata;

  mm3_ram #(.AW(MEM_AW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_q)
  );

  assign tp_rdata = ram_q;
endmodule

// File: rtl/mm3_core_chk.sv
module mm3_core_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 + 3 * (ADDR_W / 8));

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !illegal && pc == '0));

  assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !$stable(pc)) |-> (pc == $past(pc) + STEP));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_pc_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(pc));

  assert_illegal_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);

  assert_illegal_stop_R9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!busy && !done));
endmodule

bind mm3_core mm3_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .illegal(illegal), .pc(pc)
);

// File: tb/tb_mm3_core.sv
module tb_mm3_core;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int MEM_AW = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              run = 1'b0;
  logic              tp_we = 1'b0;
  logic [MEM_AW-1:0] tp_addr = '0;
  logic [7:0]        tp_wdata = '0;
  logic [7:0]        tp_rdata;
  logic              busy, done, illegal;
  logic [ADDR_W-1:0] pc;

  int checks = 0;
  int errors = 0;
  bit saw_done, saw_ill;

  mm3_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) dut (
    .clk(clk), .rst(rst), .run(run), .tp_we(tp_we), .tp_addr(tp_addr),
    .tp_wdata(tp_wdata), .tp_rdata(tp_rdata), .busy(busy), .done(done),
    .illegal(illegal), .pc(pc)
  );

  always #5ns clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic poke(input int a, input logic [7:0] d);
    @(negedge clk);
    tp_we = 1'b1; tp_addr = MEM_AW'(a); tp_wdata = d;
    @(negedge clk) tp_we = 1'b0;
  endtask

  task automatic peek(input int a, output logic [7:0] d);
    @(negedge clk) tp_addr = MEM_AW'(a);
    @(negedge clk) d = tp_rdata;
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int i = 0; i < 4; i++) poke(a + i, w[8*i +: 8]);
  endtask

  task automatic get_word(input int a, output logic [31:0] w);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      peek(a + i, b);
      w[8*i +: 8] = b;
    end
  endtask

  task automatic put_field(input int a, input logic [23:0] f);
    poke(a, f[23:16]); poke(a + 1, f[15:8]); poke(a + 2, f[7:0]);
  endtask

  task automatic put_instr(input int a, input logic [7:0] op,
                           input logic [23:0] d, input logic [23:0] s1,
                           input logic [23:0] s2);
    poke(a, op);
    put_field(a + 1, d); put_field(a + 4, s1); put_field(a + 7, s2);
  endtask

  task automatic start_and_wait();
    saw_done = 1'b0; saw_ill = 1'b0;
    @(negedge clk) run = 1'b1;
    @(negedge clk) run = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      if (done) saw_done = 1'b1;
      if (illegal) saw_ill = 1'b1;
      if (saw_done || saw_ill) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R1 done after reset", 32'(done), 0);
    chk("R1 illegal after reset", 32'(illegal), 0);
    chk("R1 pc after reset", 32'(pc), 0);
  endtask

  task automatic t_port();
    logic [7:0] b;
    poke(12'h3F0, 8'hA5); poke(12'h3F1, 8'h5A);
    peek(12'h3F0, b); chk("R2 test port byte 0", 32'(b), 32'hA5);
    peek(12'h3F1, b); chk("R2 test port byte 1", 32'(b), 32'h5A);
    poke(12'h3F0, 8'h3C);
    peek(12'h3F0, b); chk("R2 test port overwrite", 32'(b), 32'h3C);
  endtask

  task automatic t_add();
    logic [31:0] w; logic [7:0] b;
    do_reset();
    put_word(12'h210, 32'h1234_5678);
    put_word(12'h220, 32'h0FED_CBA9);
    put_instr(0, 8'h01, 24'h7F0200, 24'h000210, 24'h000220);
    put_instr(10, 8'hFF, 0, 0, 0);
    start_and_wait();
    get_word(12'h200, w);
    chk("R4 add word (R3 aliased destination)", w, 32'h2222_2221);
    peek(12'h200, b);
    chk("R4 add lowest byte first", 32'(b), 32'h21);
    chk("R8 done pulse seen", 32'(saw_done), 1);
    chk("R8 pc at halt", 32'(pc), 10);
    chk("R8 busy after halt", 32'(busy), 0);
  endtask

  task automatic t_sub();
    logic [31:0] w;
    do_reset();
    put_word(12'h210, 32'd5);
    put_word(12'h220, 32'd7);
    put_instr(0, 8'h02, 24'h000230, 24'h000210, 24'h000220);
    put_instr(10, 8'hFF, 0, 0, 0);
    start_and_wait();
    get_word(12'h230, w);
    chk("R5 sub wraps", w, 32'hFFFF_FFFE);
    get_word(12'h210, w);
    chk("R5 source untouched", w, 32'd5);
  endtask

  task automatic t_mul();
    logic [31:0] w;
    do_reset();
    put_word(12'h210, 32'h0001_0003);
    put_word(12'h220, 32'h0002_0005);
    put_instr(0, 8'h03, 24'h000234, 24'h000210, 24'h000220);
    put_instr(10, 8'hFF, 0, 0, 0);
    start_and_wait();
    get_word(12'h234, w);
    chk("R6 mul low 32 bits", w, 32'h000B_000F);
  endtask

  task automatic t_chain();
    logic [31:0] w; logic [ADDR_W-1:0] pc_hold;
    do_reset();
    put_word(12'h240, 32'd3);
    put_instr(0,  8'h01, 24'h000240, 24'h000240, 24'h000240);
    put_instr(10, 8'h03, 24'h000250, 24'h000240, 24'h000240);
    put_instr(20, 8'h02, 24'h000260, 24'h000250, 24'h000240);
    put_instr(30, 8'hFF, 0, 0, 0);
    start_and_wait();
    get_word(12'h240, w); chk("R7 in-place add", w, 32'd6);
    get_word(12'h250, w); chk("R7 later mul sees result", w, 32'd36);
    get_word(12'h260, w); chk("R7 chained sub", w, 32'd30);
    chk("R7 pc after three steps", 32'(pc), 30);
    pc_hold = pc;
    @(negedge clk) run = 1'b1;
    @(negedge clk) run = 1'b0;
    repeat (20) @(negedge clk);
    chk("R11 run ignored after halt busy", 32'(busy), 0);
    chk("R11 run ignored after halt pc", 32'(pc), 32'(pc_hold));
    get_word(12'h240, w); chk("R11 memory unchanged after run", w, 32'd6);
  endtask

  task automatic t_illegal();
    logic [31:0] w;
    do_reset();
    put_word(12'h280, 32'hDEAD_BEEF);
    put_instr(0, 8'h55, 24'h000280, 24'h000210, 24'h000220);
    start_and_wait();
    chk("R9 illegal flag", 32'(illegal), 1);
    chk("R9 no done", 32'(saw_done), 0);
    chk("R9 stopped", 32'(busy), 0);
    chk("R9 pc held", 32'(pc), 0);
    repeat (5) @(negedge clk);
    chk("R9 flag sticky", 32'(illegal), 1);
    get_word(12'h280, w);
    chk("R9 no write", w, 32'hDEAD_BEEF);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] w;
    do_reset();
    put_word(12'h2B0, 32'h1111_1111);
    put_word(12'h210, 32'd100);
    put_word(12'h220, 32'd23);
    put_instr(0, 8'h01, 24'h0002A0, 24'h000210, 24'h000220);
    put_instr(10, 8'hFF, 0, 0, 0);
    @(negedge clk) run = 1'b1;
    @(negedge clk) run = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      tp_we = 1'b1; tp_addr = MEM_AW'(12'h2B0 + i); tp_wdata = 8'hEE;
    end
    @(negedge clk) tp_we = 1'b0;
    for (int n = 0; n < 3000 && !done; n++) @(negedge clk);
    @(negedge clk);
    get_word(12'h2B0, w);
    chk("R10 writes while busy dropped", w, 32'h1111_1111);
    get_word(12'h2A0, w);
    chk("R10 run still correct", w, 32'd123);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_port();
    t_add();
    t_sub();
    t_mul();
    t_chain();
    t_illegal();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule